// File: doc/BRIEF.md
# Symmetric Space Vector PWM Gate Timer

This block turns one sampling period's worth of space-vector data into gate signals for the three upper switches of a two-level inverter, along with their inverted lower-switch partners. For each period the caller supplies a sector number from 1 to 6, the dwell times of the two active vectors on either side of the reference, and the period length, all counted in clock cycles. A one-cycle strobe marks the start of each period. At that strobe the block works out the zero-vector time and the three per-phase switching instants, and holds them for the whole period. A free-running period counter is then compared against those instants.

Consecutive periods alternate between an ascending half and a descending half. The ascending half steps through the zero state with all gates low, then the single-high active state, then the double-high active state, and ends in the all-high state. The descending half walks the same states in the reverse order. The zero time is split evenly at the two ends of each half. Because the phases are assigned per sector, only one leg changes at each vector transition.

When the two dwell times add up to more than the period, the block scales them down to fit the period exactly and raises a saturation flag for that period. Computing the dwell times from the reference angle lies outside this block, as do dead-time insertion and over-modulation strategies.

Top module: `svpwm_gate_timer`

## Requirements
- R1: After reset, and until the first period strobe, all three gates are 0, all three complements are 1 and the saturation flag is 0.
- R2: Every complement output is always the inverse of its gate output, so a gate and its complement are never both 1.
- R3: Sector, T1, T2 and Ts are sampled only in the cycle where the strobe is high. The cycle after that strobe is count 0 of the new period, and the count rises by one each cycle. Input changes at any other time have no effect on the outputs.
- R4: The first period after reset is an ascending half. After that, ascending and descending halves alternate at every strobe.
- R5: The zero time is T0 = Ts − T1 − T2, and the lead-in is H = floor(T0/2).
- R6: In an ascending half, the gate of the phase that rises first is 1 from count H onward. The second phase's gate is 1 from count H + DA onward, and the last phase's gate is 1 from count H + T1 + T2 onward. Each gate is 0 before its instant.
- R7: In a descending half, each gate is 1 below its instant and 0 from it onward. The instants are H for the last-rising phase, H + DB for the second phase and H + T1 + T2 for the first-rising phase.
- R8: Gate bit 0 is phase a, bit 1 is phase b and bit 2 is phase c. The rising order and the lead dwell DA for each sector are:
  - sector 1: a, b, c with DA = T1
  - sector 2: b, a, c with DA = T2
  - sector 3: b, c, a with DA = T1
  - sector 4: c, b, a with DA = T2
  - sector 5: c, a, b with DA = T1
  - sector 6: a, c, b with DA = T2

  In every sector, DB is the other dwell time.
- R9: If T1 + T2 > Ts, then T1 becomes floor(T1·Ts/(T1+T2)), T2 becomes Ts minus that value, and T0 becomes 0. The saturation flag is 1 for that period and returns to 0 at the next strobe that does not saturate.
- R10: A sector value of 0 or 7 is handled as T1 = T2 = 0, so the period consists of zero vectors only.
- R11: After the last instant the gates hold their final state for as long as the period lasts, including past Ts. The counter stops at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | One-cycle start-of-period strobe |
| sector | input | 3 | Sector number 1..6 (0 and 7 mean zero vectors only) |
| t1_in | input | TW | Dwell of vector V(n), in clock cycles |
| t2_in | input | TW | Dwell of vector V(n+1), in clock cycles |
| ts_in | input | TW | Sampling period, in clock cycles |
| gate_hi | output | 3 | Upper-switch gates, bit 0 = phase a |
| gate_lo | output | 3 | Lower-switch gates, inverse of gate_hi |
| sat_flag | output | 1 | Dwell times were scaled to fit this period |

## Verification
The bench builds the timer with TW = 8, so periods of a few dozen cycles are enough to reach every instant cycle by cycle. At that width a single run can cover:
- all six sectors in both halves;
- odd zero times, where the lead-in rounds down;
- zero-length dwells, where two legs switch in the same cycle;
- a scaled overload;
- periods held well beyond Ts.

The default TW = 10 only widens the counter and the divider.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    // Rising order of the phases in an ascending half, and which dwell comes first
    typedef struct packed {
        phase_e first;
        phase_e second;
        phase_e last;
        logic   lead_t2;
    } seq_t;

    function automatic logic sector_valid(input logic [2:0] s);
        return (s != 3'd0) && (s != 3'd7);
    endfunction

    function automatic seq_t sector_seq(input logic [2:0] s);
        seq_t q;
        case (s)
            3'd2:    q = '{first: PH_B, second: PH_A, last: PH_C, lead_t2: 1'b1};
            3'd3:    q = '{first: PH_B, second: PH_C, last: PH_A, lead_t2: 1'b0};
            3'd4:    q = '{first: PH_C, second: PH_B, last: PH_A, lead_t2: 1'b1};
            3'd5:    q = '{first: PH_C, second: PH_A, last: PH_B, lead_t2: 1'b0};
            3'd6:    q = '{first: PH_A, second: PH_C, last: PH_B, lead_t2: 1'b1};
            default: q = '{first: PH_A, second: PH_B, last: PH_C, lead_t2: 1'b0};
        endcase
        return q;
    endfunction

endpackage

// File: rtl/svpwm_dwell.sv
module svpwm_dwell
    import svpwm_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    sector,
    input  logic [TW-1:0] t1,
    input  logic [TW-1:0] t2,
    input  logic [TW-1:0] ts,
    output logic [TW-1:0] t1_eff,
    output logic [TW-1:0] t2_eff,
    output logic [TW-1:0] half_t0,
    output logic          sat
);
    localparam int PW = 2 * TW;

    logic          valid;
    logic [TW-1:0] t1v, t2v, t1s, t0;
    logic [TW:0]   sum, divisor;
    logic [PW-1:0] prod;

    assign valid   = sector_valid(sector);
    assign t1v     = valid ? t1 : '0;
    assign t2v     = valid ? t2 : '0;
    assign sum     = {1'b0, t1v} + {1'b0, t2v};
    assign sat     = sum > {1'b0, ts};
    assign divisor = (sum == '0) ? {{TW{1'b0}}, 1'b1} : sum;
    assign prod    = {{TW{1'b0}}, t1v} * {{TW{1'b0}}, ts};
    assign t1s     = TW'(prod / {{(TW-1){1'b0}}, divisor});

    assign t1_eff  = sat ? t1s : t1v;
    assign t2_eff  = sat ? (ts - t1s) : t2v;
    assign t0      = sat ? '0 : (ts - t1v - t2v);
    assign half_t0 = t0 >> 1;

    // Scaling only ever shortens the dwell times
    AST_SAT_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        sat |-> (t1_eff <= t1v) && (t2_eff <= t2v)); // R9

endmodule

// File: rtl/svpwm_instants.sv
module svpwm_instants
    import svpwm_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          sector,
    input  logic [TW-1:0]       t1_eff,
    input  logic [TW-1:0]       t2_eff,
    input  logic [TW-1:0]       half_t0,
    output logic [NPH-1:0][TW-1:0] thr_up,
    output logic [NPH-1:0][TW-1:0] thr_dn
);
    seq_t          seq;
    logic [TW-1:0] d_lead, d_trail, at_early, at_up_mid, at_dn_mid, at_late;

    assign seq       = sector_seq(sector);
    assign d_lead    = seq.lead_t2 ? t2_eff : t1_eff;
    assign d_trail   = seq.lead_t2 ? t1_eff : t2_eff;
    assign at_early  = half_t0;
    assign at_up_mid = half_t0 + d_lead;
    assign at_dn_mid = half_t0 + d_trail;
    assign at_late   = half_t0 + t1_eff + t2_eff;

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        always_comb begin
            if (seq.first == phase_e'(p)) begin
                thr_up[p] = at_early;
                thr_dn[p] = at_late;
            end else if (seq.second == phase_e'(p)) begin
                thr_up[p] = at_up_mid;
                thr_dn[p] = at_dn_mid;
            end else begin
                thr_up[p] = at_late;
                thr_dn[p] = at_early;
            end
        end
    end

    // Ascending instants follow the sector's rising order
    AST_UP_ORDER: assert property (@(posedge clk) disable iff (rst)
        (thr_up[seq.first] <= thr_up[seq.second]) &&
        (thr_up[seq.second] <= thr_up[seq.last])); // R8

    // Descending instants run in reverse order
    AST_DN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (thr_dn[seq.last] <= thr_dn[seq.second]) &&
        (thr_dn[seq.second] <= thr_dn[seq.first])); // R7

endmodule

// File: rtl/svpwm_leg.sv
module svpwm_leg #(
    parameter int TW = 10
) (
    input  logic [TW-1:0] cnt,
    input  logic [TW-1:0] instant,
    input  logic          ascending,
    output logic          gate
);
    assign gate = ascending ? (cnt >= instant) : (cnt < instant);
endmodule

// File: rtl/svpwm_gate_timer.sv
module svpwm_gate_timer
    import svpwm_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          period_stb,
    input  logic [2:0]    sector,
    input  logic [TW-1:0] t1_in,
    input  logic [TW-1:0] t2_in,
    input  logic [TW-1:0] ts_in,
    output logic [2:0]    gate_hi,
    output logic [2:0]    gate_lo,
    output logic          sat_flag
);
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic [TW-1:0]          t1_eff, t2_eff, half_t0;
    logic                   sat_now;
    logic [NPH-1:0][TW-1:0] thr_up, thr_dn, thr_q;
    logic [TW-1:0]          cnt;
    logic                   asc_q;

    svpwm_dwell #(.TW(TW)) u_dwell (
        .clk(clk), .rst(rst), .sector(sector),
        .t1(t1_in), .t2(t2_in), .ts(ts_in),
        .t1_eff(t1_eff), .t2_eff(t2_eff), .half_t0(half_t0), .sat(sat_now)
    );

    svpwm_instants #(.TW(TW)) u_inst (
        .clk(clk), .rst(rst), .sector(sector),
        .t1_eff(t1_eff), .t2_eff(t2_eff), .half_t0(half_t0),
        .thr_up(thr_up), .thr_dn(thr_dn)
    );

    // Period state: latched only at the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= CNT_MAX;
            asc_q    <= 1'b0;
            thr_q    <= '0;
            sat_flag <= 1'b0;
        end else if (period_stb) begin
            cnt      <= '0;
            asc_q    <= ~asc_q;
            thr_q    <= asc_q ? thr_dn : thr_up;
            sat_flag <= sat_now;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        svpwm_leg #(.TW(TW)) u_leg (
            .cnt(cnt), .instant(thr_q[p]), .ascending(asc_q), .gate(gate_hi[p])
        );
    end

    assign gate_lo = ~gate_hi;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> (cnt == '0)); // R3

    AST_THR_HELD: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> $stable(thr_q) && $stable(sat_flag)); // R3

    AST_HALF_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        period_stb |=> (asc_q != $past(asc_q))); // R4

    AST_UP_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (!period_stb && asc_q) |=> (($past(gate_hi) & ~gate_hi) == 3'b000)); // R6

    AST_DN_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!period_stb && !asc_q) |=> ((~$past(gate_hi) & gate_hi) == 3'b000)); // R7

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!period_stb && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R11

endmodule

// File: tb/svpwm_gate_timer_test.sv
module svpwm_gate_timer_test;
    localparam int TW = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 8;
    // {sector, t1, t2, ts}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd1, 8'd20, 8'd10, 8'd60},
        {8'd2, 8'd15, 8'd25, 8'd70},
        {8'd3, 8'd5,  8'd30, 8'd50},
        {8'd4, 8'd12, 8'd12, 8'd40},
        {8'd5, 8'd30, 8'd4,  8'd41},
        {8'd6, 8'd8,  8'd20, 8'd33},
        {8'd1, 8'd0,  8'd10, 8'd30},
        {8'd4, 8'd25, 8'd0,  8'd31}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          period_stb = 1'b0;
    logic [2:0]    sector = 3'd0;
    logic [TW-1:0] t1_in = '0, t2_in = '0, ts_in = '0;
    logic [2:0]    gate_hi, gate_lo;
    logic          sat_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_asc = 1'b0;
    bit  done = 1'b0;

    svpwm_gate_timer #(.TW(TW)) uut (
        .clk(clk), .rst(rst), .period_stb(period_stb), .sector(sector),
        .t1_in(t1_in), .t2_in(t2_in), .ts_in(ts_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .sat_flag(sat_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Expected gates at count k, from the requirements
    function automatic logic [2:0] model(input int sec, input int t1, input int t2,
                                         input int ts, input bit asc, input int k);
        int a, b, t0, h, o0, o1, o2;
        bit lead2;
        logic [2:0] g;
        a = (sec >= 1 && sec <= 6) ? t1 : 0;             // R10
        b = (sec >= 1 && sec <= 6) ? t2 : 0;
        if (a + b > ts) begin                            // R9
            a = (a * ts) / (a + b);
            b = ts - a;
            t0 = 0;
        end else t0 = ts - a - b;                        // R5
        h = t0 / 2;
        case (sec)                                       // R8
            2: begin o0 = 1; o1 = 0; o2 = 2; lead2 = 1; end
            3: begin o0 = 1; o1 = 2; o2 = 0; lead2 = 0; end
            4: begin o0 = 2; o1 = 1; o2 = 0; lead2 = 1; end
            5: begin o0 = 2; o1 = 0; o2 = 1; lead2 = 0; end
            6: begin o0 = 0; o1 = 2; o2 = 1; lead2 = 1; end
            default: begin o0 = 0; o1 = 1; o2 = 2; lead2 = 0; end
        endcase
        g = 3'b000;
        if (asc) begin                                   // R6
            g[o0] = (k >= h);
            g[o1] = (k >= h + (lead2 ? b : a));
            g[o2] = (k >= h + a + b);
        end else begin                                   // R7
            g[o0] = (k < h + a + b);
            g[o1] = (k < h + (lead2 ? a : b));
            g[o2] = (k < h);
        end
        return g;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One period: strobe, optional mid-period input scramble, cycle-by-cycle check
    task automatic run_period(input string req, input int sec, input int t1, input int t2,
                              input int ts, input int len, input bit scramble);
        bit exp_sat;
        @(negedge clk);
        sector = sec[2:0]; t1_in = t1[TW-1:0]; t2_in = t2[TW-1:0]; ts_in = ts[TW-1:0];
        period_stb = 1'b1;
        exp_asc = !exp_asc;                              // R4
        exp_sat = (sec >= 1 && sec <= 6) && (t1 + t2 > ts);
        @(negedge clk);
        period_stb = 1'b0;
        if (scramble) begin                              // R3: ignored mid-period
            sector = 3'd4; t1_in = 8'd3; t2_in = 8'd90; ts_in = 8'd7;
        end
        check({req, " R9 flag"}, {3'b000, sat_flag}, {3'b000, exp_sat});
        for (int k = 0; k < len; k++) begin
            logic [2:0] e;
            e = model(sec, t1, t2, ts, exp_asc, k);
            check(req, {1'b0, gate_hi}, {1'b0, e});
            check({req, " R2"}, {1'b0, gate_lo}, {1'b0, ~e});
            if (k < len - 1) @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 gates", {1'b0, gate_hi}, 4'b0000);
        check("R1 complements", {1'b0, gate_lo}, 4'b0111);
        check("R1 flag", {3'b000, sat_flag}, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle before strobe", {sat_flag, gate_hi}, 4'b0000);

        // Table walk: each vector in an ascending then a descending half
        for (int i = 0; i < NVEC; i++) begin
            for (int rep = 0; rep < 2; rep++) begin
                run_period("R6/R7/R8 table", int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                           int'(VEC[i][15:8]), int'(VEC[i][7:0]),
                           int'(VEC[i][7:0]) + 3, 1'b0);
            end
        end

        // R3: inputs changed mid-period have no effect
        run_period("R3 scramble", 3, 10, 14, 44, 47, 1'b1);
        run_period("R3 scramble", 6, 9, 11, 36, 39, 1'b1);
        // R9: overload is scaled and flagged, then cleared
        run_period("R9 saturate", 2, 50, 30, 40, 43, 1'b0);
        run_period("R9 saturate", 5, 33, 7, 20, 23, 1'b0);
        run_period("R9 clear", 1, 4, 4, 20, 23, 1'b0);
        // R10: invalid sectors give zero vectors only
        run_period("R10 sector0", 0, 10, 10, 30, 33, 1'b0);
        run_period("R10 sector7", 7, 10, 10, 30, 33, 1'b0);
        // R11: gates hold well past Ts
        run_period("R11 hold", 3, 6, 9, 25, 60, 1'b0);
        run_period("R11 hold", 3, 6, 9, 25, 60, 1'b0);

        // R1/R4: reset again, next period is ascending
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 re-reset", {sat_flag, gate_hi}, 4'b0000);
        rst = 1'b0;
        exp_asc = 1'b0;
        run_period("R4 first half ascending", 1, 10, 10, 30, 32, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule